// File: doc/BRIEF.md
# Arm Module Insertion Selector

This block decides which capacitor modules of one converter arm are switched into the current path. It receives the arm's modules as a list that an upstream sorter has already put in ascending voltage order. Each entry pairs a capacitor voltage with the physical slot of its module. The block also receives the number of modules that must be inserted, the sign of the arm current, the present insertion vector and a pair of voltage limits. From these it produces a new insertion vector with one bit per physical slot.

To keep the switching rate low, only the difference between the required count and the present count is switched, and the modules to switch are taken from the end of the sorted list that pushes the capacitor voltages back together. A positive arm current charges the inserted capacitors, so the coldest bypassed modules are inserted and the hottest inserted ones are bypassed. A negative current reverses both choices. Several modules can change in one request. List slots tagged with a negative position are fillers and are never chosen. When the count does not change but some capacitor sits at or beyond a voltage limit, one inserted module is exchanged for one bypassed module.

A controller pulses the start input once per sampling period. The selector then walks the sorted list one entry per clock and pulses its done output together with the new vector.

Top module: `arm_module_selector`

## Requirements
- R1: After reset, `ins_o` is all zero and `done_o` and `busy_o` are low.
- R2: The target count is the requested count limited to the number of valid list entries. When `done_o` is high, the number of ones in `ins_o` equals that target.
- R3: When the target differs from the present count, exactly |target − present| bits of the masked input vector change. When no exchange takes place and the counts are equal, no bit changes.
- R4: With `cur_pos_i` = 1, insertions take the bypassed valid entries nearest list index 0 (lowest voltage), and bypasses take the inserted entries nearest index N−1 (highest voltage).
- R5: With `cur_pos_i` = 0, insertions take the bypassed entries nearest index N−1, and bypasses take the inserted entries nearest index 0.
- R6: A list entry is valid when its position field is non-negative and below N. Negative positions (all ones means −1) are fillers and are never selected. Bits of `ins_now_i` at slots that no valid entry names are treated as bypassed, and they are zero in `ins_o`.
- R7: When the target equals the present count, a limit trip triggers an exchange. A trip means some valid entry has a voltage ≥ `thr_hi_i` or ≤ `thr_lo_i`. The exchange also needs at least one inserted and at least one bypassed valid module. One module is bypassed and one is inserted, chosen as in R4/R5, and both choices are judged against the state at start. Without a trip, the output equals the masked input.
- R8: `start_i` is sampled only while `busy_o` is low, and all inputs are captured on that edge. `done_o` is a one-cycle pulse, and `ins_o` changes only in that cycle. A start pulse during a busy period is ignored.
- R9: `done_o` rises no more than 2·N+3 clock cycles after the edge that samples `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, captures all inputs |
| req_cnt_i | input | CW | Required inserted-module count |
| cur_pos_i | input | 1 | 1 = arm current positive (charging) |
| thr_hi_i | input | VW | Upper voltage limit |
| thr_lo_i | input | VW | Lower voltage limit |
| ins_now_i | input | N | Present insertion vector, bit k = slot k |
| list_volt_i | input | N·VW | Sorted voltages, entry i at bits [i·VW +: VW], ascending |
| list_pos_i | input | N·PW | Signed slot of each entry, entry i at bits [i·PW +: PW] |
| ins_o | output | N | New insertion vector |
| done_o | output | 1 | One-cycle pulse, `ins_o` valid |
| busy_o | output | 1 | Request in progress |

## Verification
The assertions check several properties on every cycle. The popcount of a finished vector always matches the target. The number of changed bits always matches the planned difference. No slot without a valid entry is ever set. The done pulse lasts one cycle, the output holds between pulses, and the captured request cannot change while busy. The assertions cannot show that the right modules were picked. That depends on voltage order, current sign and the limit trip, so the bench scenarios must show it by comparing whole vectors. Those scenarios include direction, clamping, filler entries, exchanges in both current signs and a start pulse that arrives while busy.

// File: rtl/asel_pkg.sv
package asel_pkg;

    typedef enum logic [2:0] {
        SEL_IDLE,
        SEL_PLAN,
        SEL_DROP,
        SEL_ADD,
        SEL_FIN
    } sel_state_e;

endpackage

// File: rtl/asel_popcnt.sv
module asel_popcnt #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] count_o
);

    always_comb begin
        count_o = '0;
        for (int i = 0; i < W; i++) begin
            count_o = count_o + CW'(bits_i[i]);
        end
    end

endmodule

// File: rtl/asel_plan.sv
module asel_plan #(
    parameter int NUM_SM = 8,
    parameter int VW     = 12,
    parameter int PW     = $clog2(NUM_SM) + 1,
    parameter int CW     = $clog2(NUM_SM + 1)
) (
    input  logic [NUM_SM*PW-1:0] lst_pos_i,
    input  logic [NUM_SM*VW-1:0] lst_volt_i,
    input  logic [NUM_SM-1:0]    raw_vec_i,
    input  logic [CW-1:0]        req_i,
    input  logic [VW-1:0]        thr_hi_i,
    input  logic [VW-1:0]        thr_lo_i,
    output logic [NUM_SM-1:0]    exists_o,
    output logic [NUM_SM-1:0]    masked_o,
    output logic [CW-1:0]        target_o,
    output logic [CW-1:0]        add_cnt_o,
    output logic [CW-1:0]        drop_cnt_o
);

    localparam int SW = $clog2(NUM_SM);

    logic [NUM_SM-1:0] ent_valid;
    logic [NUM_SM-1:0] ent_trip;
    logic [SW-1:0]     ent_phys [NUM_SM];
    logic [CW-1:0]     valid_cnt;
    logic [CW-1:0]     pres_cnt;
    logic              trip_any;

    for (genvar g = 0; g < NUM_SM; g++) begin : g_ent
        logic [PW-1:0] pos_w;
        logic [VW-1:0] volt_w;
        assign pos_w        = lst_pos_i[g*PW +: PW];
        assign volt_w       = lst_volt_i[g*VW +: VW];
        assign ent_valid[g] = ~pos_w[PW-1] && ({1'b0, pos_w[PW-2:0]} < PW'(NUM_SM));
        assign ent_phys[g]  = pos_w[PW-2:0];
        assign ent_trip[g]  = ent_valid[g] && ((volt_w >= thr_hi_i) || (volt_w <= thr_lo_i));
    end

    always_comb begin
        exists_o = '0;
        for (int i = 0; i < NUM_SM; i++) begin
            if (ent_valid[i]) begin
                exists_o[ent_phys[i]] = 1'b1;
            end
        end
    end

    assign masked_o = raw_vec_i & exists_o;
    assign trip_any = |ent_trip;

    asel_popcnt #(.W(NUM_SM), .CW(CW)) i_cnt_valid (
        .bits_i  (ent_valid),
        .count_o (valid_cnt)
    );

    asel_popcnt #(.W(NUM_SM), .CW(CW)) i_cnt_pres (
        .bits_i  (masked_o),
        .count_o (pres_cnt)
    );

    always_comb begin
        target_o   = (req_i > valid_cnt) ? valid_cnt : req_i;
        add_cnt_o  = '0;
        drop_cnt_o = '0;
        if (target_o > pres_cnt) begin
            add_cnt_o = target_o - pres_cnt;
        end else if (target_o < pres_cnt) begin
            drop_cnt_o = pres_cnt - target_o;
        end else if (trip_any && (pres_cnt != '0) && (pres_cnt != valid_cnt)) begin
            add_cnt_o  = CW'(1);
            drop_cnt_o = CW'(1);
        end
    end

endmodule

// File: rtl/asel_pick.sv
module asel_pick #(
    parameter int NUM_SM = 8,
    parameter int PW     = $clog2(NUM_SM) + 1,
    parameter int SW     = $clog2(NUM_SM)
) (
    input  logic [NUM_SM*PW-1:0] lst_pos_i,
    input  logic [SW-1:0]        idx_i,
    input  logic [NUM_SM-1:0]    orig_i,
    input  logic                 want_on_i,
    output logic                 hit_o,
    output logic [SW-1:0]        phys_o
);

    logic [PW-1:0] pos_w;
    logic          valid_w;

    assign pos_w   = lst_pos_i[idx_i*PW +: PW];
    assign valid_w = ~pos_w[PW-1] && ({1'b0, pos_w[PW-2:0]} < PW'(NUM_SM));
    assign phys_o  = pos_w[PW-2:0];
    assign hit_o   = valid_w && (orig_i[phys_o] == want_on_i);

endmodule

// File: rtl/arm_module_selector.sv
module arm_module_selector
    import asel_pkg::*;
#(
    parameter int NUM_SM = 8,
    parameter int VW     = 12,
    parameter int PW     = $clog2(NUM_SM) + 1,
    parameter int CW     = $clog2(NUM_SM + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CW-1:0]        req_cnt_i,
    input  logic                 cur_pos_i,
    input  logic [VW-1:0]        thr_hi_i,
    input  logic [VW-1:0]        thr_lo_i,
    input  logic [NUM_SM-1:0]    ins_now_i,
    input  logic [NUM_SM*VW-1:0] list_volt_i,
    input  logic [NUM_SM*PW-1:0] list_pos_i,
    output logic [NUM_SM-1:0]    ins_o,
    output logic                 done_o,
    output logic                 busy_o
);

    localparam int SW = $clog2(NUM_SM);
    localparam int LV = NUM_SM * VW;
    localparam int LP = NUM_SM * PW;
    localparam logic [SW-1:0] LAST = SW'(NUM_SM - 1);

    typedef struct packed {
        sel_state_e        st;
        logic [SW-1:0]     step;
        logic [CW-1:0]     rem_add;
        logic [CW-1:0]     rem_drop;
        logic [CW-1:0]     target;
        logic [CW-1:0]     flips;
        logic [NUM_SM-1:0] orig;
        logic [NUM_SM-1:0] work;
        logic [NUM_SM-1:0] outv;
        logic [NUM_SM-1:0] exists;
        logic [LV-1:0]     volt;
        logic [LP-1:0]     pos;
        logic [CW-1:0]     req;
        logic              cpos;
        logic [VW-1:0]     hi;
        logic [VW-1:0]     lo;
        logic              done;
    } sel_regs_t;

    sel_regs_t r_q, r_d;

    logic [NUM_SM-1:0] pl_exists, pl_masked;
    logic [CW-1:0]     pl_target, pl_add, pl_drop;
    logic [SW-1:0]     walk_idx;
    logic              walk_rev;
    logic              pk_hit;
    logic [SW-1:0]     pk_phys;

    asel_plan #(.NUM_SM(NUM_SM), .VW(VW), .PW(PW), .CW(CW)) i_plan (
        .lst_pos_i  (r_q.pos),
        .lst_volt_i (r_q.volt),
        .raw_vec_i  (r_q.orig),
        .req_i      (r_q.req),
        .thr_hi_i   (r_q.hi),
        .thr_lo_i   (r_q.lo),
        .exists_o   (pl_exists),
        .masked_o   (pl_masked),
        .target_o   (pl_target),
        .add_cnt_o  (pl_add),
        .drop_cnt_o (pl_drop)
    );

    // drop walks from the high end under positive current, add from the low end
    assign walk_rev = r_q.cpos ^ (r_q.st == SEL_ADD);
    assign walk_idx = walk_rev ? (LAST - r_q.step) : r_q.step;

    asel_pick #(.NUM_SM(NUM_SM), .PW(PW), .SW(SW)) i_pick (
        .lst_pos_i (r_q.pos),
        .idx_i     (walk_idx),
        .orig_i    (r_q.orig),
        .want_on_i (r_q.st == SEL_DROP),
        .hit_o     (pk_hit),
        .phys_o    (pk_phys)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            SEL_IDLE: begin
                if (start_i) begin
                    r_d.volt = list_volt_i;
                    r_d.pos  = list_pos_i;
                    r_d.req  = req_cnt_i;
                    r_d.cpos = cur_pos_i;
                    r_d.hi   = thr_hi_i;
                    r_d.lo   = thr_lo_i;
                    r_d.orig = ins_now_i;
                    r_d.st   = SEL_PLAN;
                end
            end
            SEL_PLAN: begin
                r_d.orig     = pl_masked;
                r_d.work     = pl_masked;
                r_d.exists   = pl_exists;
                r_d.target   = pl_target;
                r_d.rem_add  = pl_add;
                r_d.rem_drop = pl_drop;
                r_d.flips    = pl_add + pl_drop;
                r_d.step     = '0;
                if (pl_drop != '0) begin
                    r_d.st = SEL_DROP;
                end else if (pl_add != '0) begin
                    r_d.st = SEL_ADD;
                end else begin
                    r_d.st = SEL_FIN;
                end
            end
            SEL_DROP: begin
                if (pk_hit && (r_q.rem_drop != '0)) begin
                    r_d.work[pk_phys] = 1'b0;
                    r_d.rem_drop      = r_q.rem_drop - CW'(1);
                end
                if ((r_q.step == LAST) || (pk_hit && (r_q.rem_drop == CW'(1)))) begin
                    r_d.step = '0;
                    r_d.st   = (r_q.rem_add != '0) ? SEL_ADD : SEL_FIN;
                end else begin
                    r_d.step = r_q.step + SW'(1);
                end
            end
            SEL_ADD: begin
                if (pk_hit && (r_q.rem_add != '0)) begin
                    r_d.work[pk_phys] = 1'b1;
                    r_d.rem_add       = r_q.rem_add - CW'(1);
                end
                if ((r_q.step == LAST) || (pk_hit && (r_q.rem_add == CW'(1)))) begin
                    r_d.step = '0;
                    r_d.st   = SEL_FIN;
                end else begin
                    r_d.step = r_q.step + SW'(1);
                end
            end
            SEL_FIN: begin
                r_d.outv = r_q.work;
                r_d.done = 1'b1;
                r_d.st   = SEL_IDLE;
            end
            default: r_d.st = SEL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= SEL_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign ins_o  = r_q.outv;
    assign done_o = r_q.done;
    assign busy_o = (r_q.st != SEL_IDLE);

    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones(ins_o) == int'(r_q.target))); // R2
    AST_DIFF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones(ins_o ^ r_q.orig) == int'(r_q.flips))); // R3
    AST_NO_FILLER: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((ins_o & ~r_q.exists) == '0)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(ins_o)); // R8
    AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(r_q.req)); // R8

endmodule

// File: tb/test_arm_module_selector.sv
`timescale 1ns/1ps
module test_arm_module_selector;

    localparam int N  = 8;
    localparam int VW = 12;
    localparam int PW = 4;
    localparam int CW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [CW-1:0]   req_cnt_i = '0;
    logic            cur_pos_i = 1'b0;
    logic [VW-1:0]   thr_hi_i = '0;
    logic [VW-1:0]   thr_lo_i = '0;
    logic [N-1:0]    ins_now_i = '0;
    logic [N*VW-1:0] list_volt_i = '0;
    logic [N*PW-1:0] list_pos_i = '0;
    logic [N-1:0]    ins_o;
    logic            done_o;
    logic            busy_o;

    always #2.5 clk = ~clk;

    arm_module_selector #(.NUM_SM(N), .VW(VW), .PW(PW), .CW(CW)) i_arm_module_selector (
        .clk, .rst_n, .start_i, .req_cnt_i, .cur_pos_i, .thr_hi_i, .thr_lo_i,
        .ins_now_i, .list_volt_i, .list_pos_i, .ins_o, .done_o, .busy_o
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int       bv [N];
    int       bp [N];
    logic [7:0] bvec;
    int       breq, bhi, blo;
    bit       bcpos;
    logic [7:0] e_out, e_orig, e_exist;
    int       e_tgt, e_flip;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic calc_expected();
        int nv, pres, add, drp;
        bit trip;
        nv = 0; trip = 0; e_exist = '0;
        for (int i = 0; i < N; i++) begin
            if (bp[i] >= 0) begin
                e_exist[bp[i]] = 1'b1;
                nv++;
                if (bv[i] >= bhi || bv[i] <= blo) trip = 1;
            end
        end
        e_orig = bvec & e_exist;
        pres   = $countones(e_orig);
        e_tgt  = (breq > nv) ? nv : breq;
        add = 0; drp = 0;
        if (e_tgt > pres) add = e_tgt - pres;
        else if (e_tgt < pres) drp = pres - e_tgt;
        else if (trip && pres > 0 && pres < nv) begin add = 1; drp = 1; end
        e_flip = add + drp;
        e_out  = e_orig;
        for (int k = 0; k < N; k++) begin
            int i;
            i = bcpos ? (N - 1 - k) : k;
            if (drp > 0 && bp[i] >= 0 && e_orig[bp[i]]) begin
                e_out[bp[i]] = 1'b0; drp--;
            end
        end
        for (int k = 0; k < N; k++) begin
            int i;
            i = bcpos ? k : (N - 1 - k);
            if (add > 0 && bp[i] >= 0 && !e_orig[bp[i]]) begin
                e_out[bp[i]] = 1'b1; add--;
            end
        end
    endtask

    task automatic drive_inputs();
        for (int i = 0; i < N; i++) begin
            list_volt_i[i*VW +: VW] = VW'(bv[i]);
            list_pos_i[i*PW +: PW]  = PW'(bp[i]);
        end
        req_cnt_i = CW'(breq);
        cur_pos_i = bcpos;
        thr_hi_i  = VW'(bhi);
        thr_lo_i  = VW'(blo);
        ins_now_i = bvec;
    endtask

    task automatic run_case(input string tag, input bit disturb);
        int cyc;
        logic [7:0] held;
        calc_expected();
        @(negedge clk);
        drive_inputs();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        if (disturb) begin
            req_cnt_i = CW'(breq + 3);
            ins_now_i = ~bvec;
            cur_pos_i = ~bcpos;
            start_i   = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        while (!done_o && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        chk(done_o, "R9 done seen", done_o, 1);
        chk(cyc <= 2 * N + 3, "R9 latency", cyc, 2 * N + 3);
        chk(ins_o == e_out, tag, ins_o, e_out);
        chk($countones(ins_o) == e_tgt, "R2 count", $countones(ins_o), e_tgt);
        chk($countones(ins_o ^ e_orig) == e_flip, "R3 flips", $countones(ins_o ^ e_orig), e_flip);
        chk((ins_o & ~e_exist) == 0, "R6 filler", ins_o & ~e_exist, 0);
        held = ins_o;
        @(negedge clk);
        chk(!done_o, "R8 pulse", done_o, 0);
        chk(ins_o == held, "R8 hold", ins_o, held);
    endtask

    task automatic set_full();
        for (int i = 0; i < N; i++) begin
            bv[i] = 200 + i * 100;
            bp[i] = (i * 3) % N;
        end
        bhi = 4000; blo = 10;
    endtask

    task automatic set_random();
        int perm [N];
        int nv, v, j, t;
        for (int i = 0; i < N; i++) perm[i] = i;
        for (int i = N - 1; i > 0; i--) begin
            j = $urandom % (i + 1);
            t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        end
        nv = 1 + $urandom % N;
        v  = 100;
        for (int i = 0; i < N; i++) begin
            if (i < N - nv) begin
                bv[i] = 0; bp[i] = -1;
            end else begin
                v = v + 1 + $urandom % 200;
                bv[i] = v; bp[i] = perm[i];
            end
        end
        bvec  = 8'($urandom);
        breq  = $urandom % 11;
        bcpos = 1'($urandom);
        bhi   = 1200 + $urandom % 2800;
        blo   = $urandom % 400;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ins_o == 0, "R1 out", ins_o, 0);
        chk(!done_o, "R1 done", done_o, 0);
        chk(!busy_o, "R1 busy", busy_o, 0);
        rst_n = 1'b1;

        set_full(); bvec = 8'h00; breq = 3; bcpos = 1; run_case("R4 insert low", 0);
        set_full(); bvec = 8'h00; breq = 3; bcpos = 0; run_case("R5 insert high", 0);
        set_full(); bvec = 8'hFF; breq = 2; bcpos = 1; run_case("R4 bypass high", 0);
        set_full(); bvec = 8'hFF; breq = 2; bcpos = 0; run_case("R5 bypass low", 0);
        set_full(); bvec = 8'h5A; breq = 0; bcpos = 1; run_case("R2 zero", 0);
        set_full();
        for (int i = 0; i < 3; i++) begin bv[i] = 0; bp[i] = -1; end
        bvec = 8'h00; breq = 12; bcpos = 1; run_case("R2 clamp", 0);
        set_full(); bvec = 8'h0F; breq = 4; bcpos = 1; bhi = 850; run_case("R7 swap pos", 0);
        set_full(); bvec = 8'h0F; breq = 4; bcpos = 0; blo = 250; run_case("R7 swap neg", 0);
        set_full(); bvec = 8'h0F; breq = 4; bcpos = 1; run_case("R7 no trip", 0);
        set_full(); bvec = 8'hFF; breq = 8; bcpos = 1; bhi = 300; run_case("R7 no bypassed", 0);
        set_full();
        for (int i = 0; i < 4; i++) begin bv[i] = 0; bp[i] = -1; end
        bvec = 8'hFF; breq = 4; bcpos = 0; run_case("R6 filler junk", 0);
        set_full(); bvec = 8'h11; breq = 5; bcpos = 1; run_case("R8 start ignored", 1);

        for (int n = 0; n < 300; n++) begin
            set_random();
            run_case(bcpos ? "R4 random" : "R5 random", (n % 17) == 0);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule